// File: doc/BRIEF.md
# Serial EEPROM Configuration Autoloader

This block fills a bank of configuration words from an external serial EEPROM. A load runs by itself once synchronous reset is released, and the host can start another one by writing a control word with the load-command bit set. Each word is fetched over a four-wire serial link (select, clock, data toward the device, data from the device). The words arrive in a shadow buffer. The live configuration outputs are updated from that buffer only when the device has answered and the image checksum matches.

While a load runs, every host register access is refused with a retry indication. Status outputs report four things: the image is valid, a device was detected, a load is running, and host control of the serial port is enabled. When the serial port is neither loading nor under host control, select is held low and the clock and data pins carry two LED signals. The first `PROM_WORDS` words are address-PROM words. They survive a failed load, while the remaining programmable words return to their defaults.

Top module: `eeprom_autoload`

## Requirements
- R1: In the cycle after synchronous reset is released, `stat_busy` is 1 and `stat_valid` is 0. A load then starts without host action. During reset, the address-PROM words are 0 and programmable word i is 16'h5A00+i.
- R2: A write with `ctl_wr`=1 and `ctl_rd_cmd`=1 while idle makes `stat_busy` 1 and `stat_valid` 0 from the next cycle. `stat_busy` clears itself when the load ends.
- R3: `stat_valid` becomes 1 at the end of a load only if the device answered every word and the low byte of the last word equals the 8-bit sum of both bytes of all other words. Otherwise it stays 0.
- R4: Each word is fetched as follows. Select goes high. The clock has a period of 2*CLK_DIV cycles, and the device samples `ee_di` on its rising edge. The block sends start bit 1, opcode 2'b10 and a 6-bit address, MSB first. It then reads one dummy bit followed by 16 data bits, MSB first. Words are fetched in address order 0 to NWORDS-1, with select low between words.
- R5: If the dummy bit reads 1, the device is absent. The load stops after that first word, `stat_valid` stays 0, programmable words take their defaults, and address-PROM words keep their values.
- R6: On a checksum mismatch, programmable words take their defaults and address-PROM words keep their previous values.
- R7: On a passing load, all words 0 to NWORDS-2 appear on `cfg_words`, with word i at bits [16i+15:16i].
- R8: `stat_detect` is written only at the end of the load that follows reset. Loads started by the host leave it unchanged.
- R9: A host access (`ctl_wr` or `host_rd`) gives `acc_retry`=1 and `acc_ack`=0 one cycle later if a load is running. Otherwise it gives `acc_ack`=1 and `acc_retry`=0.
- R10: Control writes made while a load is running have no effect on port enable or the host pin bits.
- R11: The pins are registered and lag the control state by one cycle. With port enable 1 and idle, `ctl_cs`/`ctl_sk`/`ctl_di` drive `ee_cs`/`ee_sk`/`ee_di`. With port enable 0 and idle, `ee_cs` is 0, `ee_sk` follows `led_sk_src` and `ee_di` follows `led_di_src`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_wr | input | 1 | Host write strobe to the control word |
| ctl_rd_cmd | input | 1 | Load-command bit of the control write |
| ctl_port_en | input | 1 | Port-enable bit of the control write |
| ctl_cs | input | 1 | Host select bit |
| ctl_sk | input | 1 | Host clock bit |
| ctl_di | input | 1 | Host data bit |
| host_rd | input | 1 | Host read access strobe |
| led_sk_src | input | 1 | LED signal shown on the clock pin when idle |
| led_di_src | input | 1 | LED signal shown on the data pin when idle |
| ee_do | input | 1 | Serial data from the EEPROM (pulled high when absent) |
| ee_cs | output | 1 | EEPROM select |
| ee_sk | output | 1 | EEPROM serial clock |
| ee_di | output | 1 | Serial data to the EEPROM |
| stat_valid | output | 1 | Image loaded and checksum correct |
| stat_detect | output | 1 | Device found by the reset-time load |
| stat_busy | output | 1 | Load running (load-command bit) |
| stat_port_en | output | 1 | Host control of the serial pins |
| acc_ack | output | 1 | Host access accepted |
| acc_retry | output | 1 | Host access refused, retry later |
| cfg_words | output | (NWORDS-1)*16 | Committed configuration words |

## Verification
The hardest case to reach is a failed load that follows a good one. Only then can it be seen that the address-PROM words keep the earlier image while the programmable words fall back to their defaults. The stimulus walks a table of image seeds against a bus-level EEPROM model. The table mixes passing images, images with a deliberately corrupted checksum byte and an absent device, so that each kind of failure meets a known prior state. A second reset with the device removed, followed by a host load with it restored, shows that the detect flag depends only on the reset-time load.

// File: rtl/eeld_pkg.sv
package eeld_pkg;
  typedef enum logic [1:0] {SQ_IDLE, SQ_LAUNCH, SQ_WAIT, SQ_FINISH} seq_state_t;
  typedef enum logic [1:0] {EN_IDLE, EN_XFER, EN_GAP} eng_state_t;

  localparam int ADDR_W     = 6;
  localparam int CMD_BITS   = 3 + ADDR_W;          // start, opcode, address
  localparam int DUMMY_SLOT = CMD_BITS;            // slot that carries the presence bit
  localparam int LAST_SLOT  = DUMMY_SLOT + 16;     // last data slot
  localparam logic [2:0] READ_HDR = 3'b110;        // start bit + read opcode

  function automatic logic [15:0] dflt_word(input int idx);
    return 16'h5A00 + idx[15:0];
  endfunction
endpackage

// File: rtl/eeld_serial.sv
module eeld_serial
  import eeld_pkg::*;
#(
  parameter int CLK_DIV = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [ADDR_W-1:0] addr,
  input  logic              sdo,
  output logic              cs,
  output logic              sk,
  output logic              sdi,
  output logic              done,
  output logic              present,
  output logic [15:0]       data
);
  localparam int PW = $clog2(2 * CLK_DIV);
  localparam int SW = $clog2(LAST_SLOT + 1);
  localparam logic [PW-1:0] PH_LAST = PW'(2 * CLK_DIV - 1);
  localparam logic [PW-1:0] PH_HIGH = PW'(CLK_DIV);

  eng_state_t        st;
  logic [PW-1:0]     ph;
  logic [SW-1:0]     slot;
  logic [CMD_BITS-1:0] cmd;
  logic [15:0]       shift;
  logic              pres;

  always_ff @(posedge clk) begin
    if (rst) begin
      st    <= EN_IDLE;
      ph    <= '0;
      slot  <= '0;
      cmd   <= '0;
      shift <= '0;
      pres  <= 1'b0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        EN_IDLE: begin
          if (start) begin
            st   <= EN_XFER;
            ph   <= '0;
            slot <= '0;
            cmd  <= {READ_HDR, addr};
          end
        end
        EN_XFER: begin
          if (ph == PH_LAST) begin
            ph <= '0;
            if (slot == SW'(DUMMY_SLOT)) begin
              pres <= ~sdo;
              if (sdo) st <= EN_GAP;
              else     slot <= slot + 1'b1;
            end else if (slot > SW'(DUMMY_SLOT)) begin
              shift <= {shift[14:0], sdo};
              if (slot == SW'(LAST_SLOT)) st <= EN_GAP;
              else                        slot <= slot + 1'b1;
            end else begin
              cmd  <= {cmd[CMD_BITS-2:0], 1'b0};
              slot <= slot + 1'b1;
            end
          end else begin
            ph <= ph + 1'b1;
          end
        end
        default: begin
          if (ph == PH_LAST) begin
            ph   <= '0;
            st   <= EN_IDLE;
            done <= 1'b1;
          end else begin
            ph <= ph + 1'b1;
          end
        end
      endcase
    end
  end

  always_comb begin
    cs  = (st == EN_XFER);
    sk  = (st == EN_XFER) && (ph >= PH_HIGH);
    sdi = (st == EN_XFER) && (slot < SW'(DUMMY_SLOT)) && cmd[CMD_BITS-1];
  end

  assign present = pres;
  assign data    = shift;
endmodule

// File: rtl/eeld_cfg_store.sv
module eeld_cfg_store
  import eeld_pkg::*;
#(
  parameter int NWORDS     = 8,
  parameter int PROM_WORDS = 3
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       wr_en,
  input  logic [$clog2(NWORDS)-1:0]  wr_idx,
  input  logic [15:0]                wr_data,
  input  logic                       commit,
  input  logic                       revert,
  output logic [(NWORDS-1)*16-1:0]   cfg_flat
);
  localparam int CW = NWORDS - 1;
  localparam int IW = $clog2(NWORDS);

  logic [15:0] shadow [CW];

  always_ff @(posedge clk) begin
    if (wr_en && (wr_idx < IW'(CW))) shadow[wr_idx] <= wr_data;
  end

  for (genvar g = 0; g < CW; g++) begin : g_word
    logic [15:0] live;
    always_ff @(posedge clk) begin
      if (rst) begin
        live <= (g < PROM_WORDS) ? 16'h0000 : dflt_word(g);
      end else if (commit) begin
        live <= shadow[g];
      end else if (revert && (g >= PROM_WORDS)) begin
        live <= dflt_word(g);
      end
    end
    assign cfg_flat[g*16 +: 16] = live;
  end
endmodule

// File: rtl/eeld_pinmux.sv
module eeld_pinmux (
  input  logic clk,
  input  logic rst,
  input  logic busy,
  input  logic port_en,
  input  logic h_cs,
  input  logic h_sk,
  input  logic h_di,
  input  logic e_cs,
  input  logic e_sk,
  input  logic e_di,
  input  logic led_sk,
  input  logic led_di,
  output logic pin_cs,
  output logic pin_sk,
  output logic pin_di
);
  always_ff @(posedge clk) begin
    if (rst) begin
      pin_cs <= 1'b0;
      pin_sk <= 1'b0;
      pin_di <= 1'b0;
    end else if (busy) begin
      pin_cs <= e_cs;
      pin_sk <= e_sk;
      pin_di <= e_di;
    end else if (port_en) begin
      pin_cs <= h_cs;
      pin_sk <= h_sk;
      pin_di <= h_di;
    end else begin
      pin_cs <= 1'b0;
      pin_sk <= led_sk;
      pin_di <= led_di;
    end
  end
endmodule

// File: rtl/eeprom_autoload.sv
module eeprom_autoload
  import eeld_pkg::*;
#(
  parameter int NWORDS     = 8,
  parameter int PROM_WORDS = 3,
  parameter int CLK_DIV    = 4
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     ctl_wr,
  input  logic                     ctl_rd_cmd,
  input  logic                     ctl_port_en,
  input  logic                     ctl_cs,
  input  logic                     ctl_sk,
  input  logic                     ctl_di,
  input  logic                     host_rd,
  input  logic                     led_sk_src,
  input  logic                     led_di_src,
  input  logic                     ee_do,
  output logic                     ee_cs,
  output logic                     ee_sk,
  output logic                     ee_di,
  output logic                     stat_valid,
  output logic                     stat_detect,
  output logic                     stat_busy,
  output logic                     stat_port_en,
  output logic                     acc_ack,
  output logic                     acc_retry,
  output logic [(NWORDS-1)*16-1:0] cfg_words
);
  localparam int IW = $clog2(NWORDS);
  localparam logic [IW-1:0] LAST_IDX = IW'(NWORDS - 1);

  seq_state_t  sq;
  logic [IW-1:0] idx;
  logic [7:0]  sum;
  logic        ok, found, auto_ld;
  logic        h_cs, h_sk, h_di;
  logic        eng_start, eng_cs, eng_sk, eng_di, eng_done, eng_present;
  logic [15:0] eng_data;
  logic        sh_wr, do_commit, do_revert;

  assign eng_start = (sq == SQ_LAUNCH);
  assign sh_wr     = (sq == SQ_WAIT) && eng_done && eng_present;
  assign do_commit = (sq == SQ_FINISH) && ok;
  assign do_revert = (sq == SQ_FINISH) && !ok;

  always_ff @(posedge clk) begin
    if (rst) begin
      sq           <= SQ_LAUNCH;
      stat_busy    <= 1'b1;
      stat_valid   <= 1'b0;
      stat_detect  <= 1'b0;
      stat_port_en <= 1'b0;
      auto_ld      <= 1'b1;
      idx          <= '0;
      sum          <= '0;
      ok           <= 1'b0;
      found        <= 1'b0;
      h_cs         <= 1'b0;
      h_sk         <= 1'b0;
      h_di         <= 1'b0;
      acc_ack      <= 1'b0;
      acc_retry    <= 1'b0;
    end else begin
      acc_retry <= (ctl_wr | host_rd) & stat_busy;
      acc_ack   <= (ctl_wr | host_rd) & ~stat_busy;
      case (sq)
        SQ_IDLE: begin
          if (ctl_wr) begin
            stat_port_en <= ctl_port_en;
            h_cs         <= ctl_cs;
            h_sk         <= ctl_sk;
            h_di         <= ctl_di;
            if (ctl_rd_cmd) begin
              stat_busy  <= 1'b1;
              stat_valid <= 1'b0;
              auto_ld    <= 1'b0;
              idx        <= '0;
              sum        <= '0;
              sq         <= SQ_LAUNCH;
            end
          end
        end
        SQ_LAUNCH: sq <= SQ_WAIT;
        SQ_WAIT: begin
          if (eng_done) begin
            if (!eng_present) begin
              ok    <= 1'b0;
              found <= 1'b0;
              sq    <= SQ_FINISH;
            end else begin
              found <= 1'b1;
              if (idx == LAST_IDX) begin
                ok <= (eng_data[7:0] == sum);
                sq <= SQ_FINISH;
              end else begin
                sum <= sum + eng_data[15:8] + eng_data[7:0];
                idx <= idx + 1'b1;
                sq  <= SQ_LAUNCH;
              end
            end
          end
        end
        default: begin
          stat_busy  <= 1'b0;
          stat_valid <= ok;
          if (auto_ld) stat_detect <= found;
          sq <= SQ_IDLE;
        end
      endcase
    end
  end

  eeld_serial #(.CLK_DIV(CLK_DIV)) u_serial (
    .clk(clk), .rst(rst), .start(eng_start), .addr(ADDR_W'(idx)), .sdo(ee_do),
    .cs(eng_cs), .sk(eng_sk), .sdi(eng_di), .done(eng_done),
    .present(eng_present), .data(eng_data)
  );

  eeld_cfg_store #(.NWORDS(NWORDS), .PROM_WORDS(PROM_WORDS)) u_store (
    .clk(clk), .rst(rst), .wr_en(sh_wr), .wr_idx(idx), .wr_data(eng_data),
    .commit(do_commit), .revert(do_revert), .cfg_flat(cfg_words)
  );

  eeld_pinmux u_pins (
    .clk(clk), .rst(rst), .busy(stat_busy), .port_en(stat_port_en),
    .h_cs(h_cs), .h_sk(h_sk), .h_di(h_di),
    .e_cs(eng_cs), .e_sk(eng_sk), .e_di(eng_di),
    .led_sk(led_sk_src), .led_di(led_di_src),
    .pin_cs(ee_cs), .pin_sk(ee_sk), .pin_di(ee_di)
  );
endmodule

// File: rtl/eeprom_autoload_chk.sv
module eeprom_autoload_chk (
  input logic clk,
  input logic rst,
  input logic ctl_wr,
  input logic ctl_rd_cmd,
  input logic host_rd,
  input logic ee_cs,
  input logic ee_sk,
  input logic stat_valid,
  input logic stat_detect,
  input logic stat_busy,
  input logic stat_port_en,
  input logic acc_ack,
  input logic acc_retry
);
  a_r1_reset_state: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (stat_busy && !stat_valid));

  a_r2_cmd_clears_valid: assert property (@(posedge clk) disable iff (rst)
    (ctl_wr && ctl_rd_cmd && !stat_busy) |=> (stat_busy && !stat_valid));

  a_r3_valid_at_load_end: assert property (@(posedge clk) disable iff (rst)
    $rose(stat_valid) |-> $fell(stat_busy));

  a_r4_no_clock_unselected: assert property (@(posedge clk) disable iff (rst)
    stat_busy |=> (ee_cs || !ee_sk));

  a_r8_detect_hold: assert property (@(posedge clk) disable iff (rst)
    !$fell(stat_busy) |-> $stable(stat_detect));

  a_r9_retry_when_busy: assert property (@(posedge clk) disable iff (rst)
    (host_rd && stat_busy) |=> (acc_retry && !acc_ack));

  a_r9_ack_retry_excl: assert property (@(posedge clk) disable iff (rst)
    !(acc_ack && acc_retry));

  a_r11_cs_low_idle: assert property (@(posedge clk) disable iff (rst)
    (!stat_busy && !stat_port_en) |=> !ee_cs);
endmodule

bind eeprom_autoload eeprom_autoload_chk u_chk (
  .clk(clk), .rst(rst), .ctl_wr(ctl_wr), .ctl_rd_cmd(ctl_rd_cmd), .host_rd(host_rd),
  .ee_cs(ee_cs), .ee_sk(ee_sk), .stat_valid(stat_valid), .stat_detect(stat_detect),
  .stat_busy(stat_busy), .stat_port_en(stat_port_en), .acc_ack(acc_ack),
  .acc_retry(acc_retry)
);

// File: tb/tb_eeprom_autoload.sv
module tb_eeprom_autoload;
  localparam int CLK_PERIOD = 10;
  localparam int NW   = 6;
  localparam int PROM = 2;
  localparam int DIV  = 2;
  localparam int CWB  = (NW - 1) * 16;

  // {device present, corrupt checksum, seed}
  localparam logic [17:0] VEC [6] = '{
    {1'b1, 1'b0, 16'h2461}, {1'b1, 1'b1, 16'h3C0F}, {1'b0, 1'b0, 16'h7777},
    {1'b1, 1'b0, 16'h9AB3}, {1'b1, 1'b1, 16'h0F0F}, {1'b1, 1'b0, 16'hE5D2}
  };

  logic clk = 1'b0, rst = 1'b1;
  logic ctl_wr = 0, ctl_rd_cmd = 0, ctl_port_en = 0, ctl_cs = 0, ctl_sk = 0, ctl_di = 0;
  logic host_rd = 0, led_sk_src = 0, led_di_src = 0;
  logic ee_do, ee_cs, ee_sk, ee_di;
  logic stat_valid, stat_detect, stat_busy, stat_port_en, acc_ack, acc_retry;
  logic [CWB-1:0] cfg_words;

  int checks = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  eeprom_autoload #(.NWORDS(NW), .PROM_WORDS(PROM), .CLK_DIV(DIV)) dut (
    .clk(clk), .rst(rst), .ctl_wr(ctl_wr), .ctl_rd_cmd(ctl_rd_cmd),
    .ctl_port_en(ctl_port_en), .ctl_cs(ctl_cs), .ctl_sk(ctl_sk), .ctl_di(ctl_di),
    .host_rd(host_rd), .led_sk_src(led_sk_src), .led_di_src(led_di_src),
    .ee_do(ee_do), .ee_cs(ee_cs), .ee_sk(ee_sk), .ee_di(ee_di),
    .stat_valid(stat_valid), .stat_detect(stat_detect), .stat_busy(stat_busy),
    .stat_port_en(stat_port_en), .acc_ack(acc_ack), .acc_retry(acc_retry),
    .cfg_words(cfg_words)
  );

  // EEPROM model
  logic [15:0] img [NW];
  logic dev_on = 1'b1;
  logic model_do = 1'b1;
  logic [8:0] capt = '0;
  logic [5:0] cur_addr = '0;
  int nedge = 0, cs_rises = 0, frame_err = 0, words_seen = 0;
  assign ee_do = model_do;

  always @(posedge ee_cs) begin
    nedge = 0;
    cs_rises++;
  end
  always @(negedge ee_cs) model_do = 1'b1;
  always @(posedge ee_sk) begin
    if (ee_cs && dev_on) begin
      nedge++;
      if (nedge <= 9) capt = {capt[7:0], ee_di};
      if (nedge == 9) begin
        if (capt[8:6] != 3'b110) frame_err++;
        if (capt[5:0] != 6'(words_seen)) frame_err++;
        cur_addr = capt[5:0];
        words_seen++;
      end
      if (nedge == 10) model_do = 1'b0;
      if (nedge >= 11 && nedge <= 26) model_do = img[cur_addr][26 - nedge];
    end
  end

  logic [15:0] exp_prom [PROM];
  logic [CWB-1:0] expv;

  task automatic check(input logic ok, input string req, input logic [CWB-1:0] act,
                       input logic [CWB-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic build_image(input logic [15:0] seed, input logic bad);
    logic [7:0] s;
    s = 8'h00;
    for (int i = 0; i < NW - 1; i++) begin
      img[i] = seed ^ (16'(i) * 16'h1357);
      s = s + img[i][15:8] + img[i][7:0];
    end
    img[NW-1] = {8'h00, s ^ (bad ? 8'h01 : 8'h00)};
  endtask

  task automatic exp_cfg(input logic good);
    for (int i = 0; i < NW - 1; i++) begin
      if (good) expv[i*16 +: 16] = img[i];
      else if (i < PROM) expv[i*16 +: 16] = exp_prom[i];
      else expv[i*16 +: 16] = 16'h5A00 + 16'(i);
    end
  endtask

  task automatic wait_idle();
    int n;
    n = 0;
    while (stat_busy && n < 20000) begin
      @(negedge clk);
      n++;
    end
    if (stat_busy) check(1'b0, "watchdog", '0, '0);
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    repeat (3) @(negedge clk);
    cs_rises = 0; words_seen = 0; frame_err = 0;
    rst = 1'b0;
    @(negedge clk);
  endtask

  task automatic start_load();
    cs_rises = 0; words_seen = 0; frame_err = 0;
    @(negedge clk); ctl_wr = 1; ctl_rd_cmd = 1;
    @(negedge clk); ctl_wr = 0; ctl_rd_cmd = 0;
    check(stat_busy && !stat_valid, "R2 busy set valid cleared",
          CWB'({stat_busy, stat_valid}), CWB'(2'b10));
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < PROM; i++) exp_prom[i] = 16'h0000;
    // reset-triggered load with a device present
    build_image(16'h1000, 1'b0);
    dev_on = 1'b1;
    do_reset();
    check(stat_busy && !stat_valid, "R1 reset status", CWB'({stat_busy, stat_valid}), CWB'(2'b10));
    exp_cfg(1'b0);
    check(cfg_words == expv, "R1 reset defaults", cfg_words, expv);
    wait_idle();
    check(stat_valid, "R3 valid after auto load", CWB'(stat_valid), CWB'(1));
    check(stat_detect, "R8 detect after reset load", CWB'(stat_detect), CWB'(1));
    exp_cfg(1'b1);
    check(cfg_words == expv, "R7 auto load committed", cfg_words, expv);
    check(frame_err == 0 && words_seen == NW, "R4 frame and word order",
          CWB'(frame_err * 256 + words_seen), CWB'(NW));
    for (int i = 0; i < PROM; i++) exp_prom[i] = img[i];

    // retry and ignored control writes during a load (R9, R10)
    start_load();
    host_rd = 1; @(negedge clk); host_rd = 0;
    check(acc_retry && !acc_ack, "R9 retry while busy", CWB'({acc_retry, acc_ack}), CWB'(2'b10));
    ctl_wr = 1; ctl_port_en = 1; ctl_cs = 1; @(negedge clk); ctl_wr = 0;
    wait_idle();
    @(negedge clk);
    check(!stat_port_en, "R10 write during load ignored", CWB'(stat_port_en), CWB'(0));
    check(!ee_cs, "R10 pins unchanged by ignored write", CWB'(ee_cs), CWB'(0));
    ctl_port_en = 0; ctl_cs = 0;
    for (int i = 0; i < PROM; i++) exp_prom[i] = img[i];

    // table of loads
    for (int v = 0; v < 6; v++) begin
      logic [17:0] e;
      logic good;
      e = VEC[v];
      build_image(e[15:0], e[16]);
      dev_on = e[17];
      good = e[17] && !e[16];
      start_load();
      wait_idle();
      check(stat_valid == good, "R3 valid per image", CWB'(stat_valid), CWB'(good));
      exp_cfg(good);
      check(cfg_words == expv, good ? "R7 committed words" : "R6 R5 defaults and PROM kept",
            cfg_words, expv);
      if (e[17]) begin
        check(frame_err == 0 && words_seen == NW && cs_rises == NW, "R4 full fetch",
              CWB'(cs_rises), CWB'(NW));
      end else begin
        check(cs_rises == 1, "R5 abort after first word", CWB'(cs_rises), CWB'(1));
      end
      check(stat_detect, "R8 detect unchanged by host load", CWB'(stat_detect), CWB'(1));
      if (good) for (int i = 0; i < PROM; i++) exp_prom[i] = img[i];
    end
    dev_on = 1'b1;

    // idle access is acknowledged
    host_rd = 1; @(negedge clk); host_rd = 0;
    check(acc_ack && !acc_retry, "R9 ack when idle", CWB'({acc_retry, acc_ack}), CWB'(2'b01));

    // pin sharing
    ctl_wr = 1; ctl_port_en = 1; ctl_cs = 1; ctl_sk = 0; ctl_di = 1;
    @(negedge clk); ctl_wr = 0;
    @(negedge clk);
    check({ee_cs, ee_sk, ee_di} == 3'b101, "R11 host drives pins",
          CWB'({ee_cs, ee_sk, ee_di}), CWB'(3'b101));
    ctl_wr = 1; ctl_port_en = 0; led_sk_src = 1; led_di_src = 0;
    @(negedge clk); ctl_wr = 0;
    @(negedge clk);
    check({ee_cs, ee_sk, ee_di} == 3'b010, "R11 LED on pins a",
          CWB'({ee_cs, ee_sk, ee_di}), CWB'(3'b010));
    led_sk_src = 0; led_di_src = 1;
    @(negedge clk);
    check({ee_cs, ee_sk, ee_di} == 3'b001, "R11 LED on pins b",
          CWB'({ee_cs, ee_sk, ee_di}), CWB'(3'b001));
    led_di_src = 0;

    // reset with the device absent, then host load with it present
    dev_on = 1'b0;
    for (int i = 0; i < PROM; i++) exp_prom[i] = 16'h0000;
    do_reset();
    wait_idle();
    check(!stat_detect && !stat_valid, "R5 R8 absent at reset",
          CWB'({stat_detect, stat_valid}), CWB'(0));
    exp_cfg(1'b0);
    check(cfg_words == expv, "R5 defaults after absent load", cfg_words, expv);
    dev_on = 1'b1;
    build_image(16'h4242, 1'b0);
    start_load();
    wait_idle();
    check(stat_valid && !stat_detect, "R8 host load leaves detect",
          CWB'({stat_valid, stat_detect}), CWB'(2'b10));

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule